// File: doc/BRIEF.md
# DMA Bus Arbiter with Starvation Escalation

This block decides, once per transfer slot, which of several DMA channels gets the memory bus. Every channel has a fixed rank given by its index, and index 0 ranks highest. A channel that is about to starve is raised above every request that is not urgent, whatever its rank. Peripheral channels occupy indices 0 to `NUM_PER-1`. Memory-to-memory channels follow at indices `NUM_PER` to `NUM_PER+NUM_MEM-1`.

A peripheral channel raises a bus request when its peripheral asks for data or when a descriptor fetch is pending. The channel is starving when its FIFO cannot take part in a bus transfer and its peripheral is still asking. For a transmit channel that means the FIFO is empty; for a receive channel it means the FIFO is full. A pending descriptor fetch on a starving channel is urgent, because the chain for that channel has to continue.

A memory-to-memory channel with handshaking on becomes urgent when its request-edge count goes above its threshold. With handshaking off, its urgency comes from a bit that software writes. The winner is registered and shows up as a one-hot grant one cycle later, together with a flag that marks grants won on the urgent path.

Top module: `dma_urgent_arb`

## Requirements
- R1: After a synchronous active-high reset, `grant` and `grant_urgent` read zero.
- R2: A peripheral channel is urgent exactly when `per_req` is high and its FIFO is blocked. The FIFO is blocked when it is empty for `per_tx`=1 (transmit) and when it is full for `per_tx`=0 (receive).
- R3: When any urgent request exists, the granted channel is an urgent one, even if a lower index has a non-urgent request.
- R4: A peripheral channel requests the bus when `per_req` or `desc_pend` is high. A descriptor fetch pending without a peripheral request is served only on the non-urgent path.
- R5: With `mem_hs_en` high, a requesting memory channel is urgent exactly when `mem_edge_cnt` > `mem_urg_thr`, using unsigned comparison. A threshold of all ones never makes the channel urgent.
- R6: With `mem_hs_en` low, the urgency of a requesting memory channel equals `mem_sw_urg`, and `mem_edge_cnt` and `mem_urg_thr` have no effect.
- R7: Within the urgent class, and also within the non-urgent class, the lowest index wins.
- R8: Inputs sampled at clock edge k decide `grant` after edge k. If `bus_rdy` was low at edge k, `grant` is all zeros after it.
- R9: `grant_urgent` is high exactly in the cycles whose grant came from the urgent path.
- R10: `grant` has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rdy | input | 1 | Bus can accept a transfer in this slot |
| per_req | input | NUM_PER | Peripheral DMA request line per channel |
| per_tx | input | NUM_PER | 1 = transmit FIFO, 0 = receive FIFO |
| fifo_empty | input | NUM_PER | Channel FIFO empty |
| fifo_full | input | NUM_PER | Channel FIFO full |
| desc_pend | input | NUM_PER | Descriptor fetch pending |
| mem_req | input | NUM_MEM | Memory-to-memory channel request |
| mem_hs_en | input | NUM_MEM | Handshake mode enable |
| mem_sw_urg | input | NUM_MEM | Software urgency bit |
| mem_edge_cnt | input | NUM_MEM*CNT_W | Request-edge count per channel, packed |
| mem_urg_thr | input | NUM_MEM*CNT_W | Urgency threshold per channel, packed |
| grant | output | NUM_PER+NUM_MEM | Registered one-hot grant |
| grant_urgent | output | 1 | Current grant came from the urgent path |

## Verification
The bench builds the arbiter with two peripheral channels, one memory-to-memory channel and a 3-bit count width. At that size every combination of the ten peripheral input bits is driven, and so is every combination of the memory channel's request, mode, software bit, count and threshold. The all-ones threshold of 7 and each boundary where the count equals the threshold are therefore covered. Each peripheral pattern is also mixed with varying memory-channel requests and with stalled slots.

// File: rtl/dua_pkg.sv
package dua_pkg;
    typedef enum logic {
        FIFO_RX = 1'b0,
        FIFO_TX = 1'b1
    } fifo_dir_e;

    // FIFO cannot move a word over the bus in the current slot
    function automatic logic fifo_blocked(input fifo_dir_e dir,
                                          input logic empty,
                                          input logic full);
        return (dir == FIFO_TX) ? empty : full;
    endfunction
endpackage

// File: rtl/dua_per_urg.sv
module dua_per_urg #(
    parameter int NUM_PER = 4
) (
    input  logic [NUM_PER-1:0] per_req,
    input  logic [NUM_PER-1:0] per_tx,
    input  logic [NUM_PER-1:0] fifo_empty,
    input  logic [NUM_PER-1:0] fifo_full,
    input  logic [NUM_PER-1:0] desc_pend,
    output logic [NUM_PER-1:0] req_o,
    output logic [NUM_PER-1:0] urg_o
);
    import dua_pkg::*;

    for (genvar g = 0; g < NUM_PER; g++) begin : g_ch
        logic starving;
        always_comb begin
            starving = per_req[g] &&
                       fifo_blocked(fifo_dir_e'(per_tx[g]), fifo_empty[g], fifo_full[g]);
            // data or descriptor work both need the bus
            req_o[g] = per_req[g] | desc_pend[g];
            // a descriptor fetch for a starving channel is urgent as well
            urg_o[g] = starving;
        end
    end
endmodule

// File: rtl/dua_mem_urg.sv
module dua_mem_urg #(
    parameter int NUM_MEM = 2,
    parameter int CNT_W   = 8
) (
    input  logic [NUM_MEM-1:0]       mem_req,
    input  logic [NUM_MEM-1:0]       mem_hs_en,
    input  logic [NUM_MEM-1:0]       mem_sw_urg,
    input  logic [NUM_MEM*CNT_W-1:0] mem_edge_cnt,
    input  logic [NUM_MEM*CNT_W-1:0] mem_urg_thr,
    output logic [NUM_MEM-1:0]       req_o,
    output logic [NUM_MEM-1:0]       urg_o
);
    for (genvar g = 0; g < NUM_MEM; g++) begin : g_ch
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] thr;
        logic             hs_urg;
        always_comb begin
            cnt      = mem_edge_cnt[g*CNT_W +: CNT_W];
            thr      = mem_urg_thr[g*CNT_W +: CNT_W];
            hs_urg   = !(&thr) && (cnt > thr);
            req_o[g] = mem_req[g];
            urg_o[g] = mem_req[g] && (mem_hs_en[g] ? hs_urg : mem_sw_urg[g]);
        end
    end
endmodule

// File: rtl/dua_pick.sv
module dua_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign gnt[g]    = req[g] & ~seen[g];
        assign seen[g+1] = seen[g] | req[g];
    end

    assign any = seen[N];
endmodule

// File: rtl/dma_urgent_arb.sv
module dma_urgent_arb #(
    parameter int NUM_PER = 4,
    parameter int NUM_MEM = 2,
    parameter int CNT_W   = 8,
    localparam int N      = NUM_PER + NUM_MEM
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_rdy,
    input  logic [NUM_PER-1:0]       per_req,
    input  logic [NUM_PER-1:0]       per_tx,
    input  logic [NUM_PER-1:0]       fifo_empty,
    input  logic [NUM_PER-1:0]       fifo_full,
    input  logic [NUM_PER-1:0]       desc_pend,
    input  logic [NUM_MEM-1:0]       mem_req,
    input  logic [NUM_MEM-1:0]       mem_hs_en,
    input  logic [NUM_MEM-1:0]       mem_sw_urg,
    input  logic [NUM_MEM*CNT_W-1:0] mem_edge_cnt,
    input  logic [NUM_MEM*CNT_W-1:0] mem_urg_thr,
    output logic [N-1:0]             grant,
    output logic                     grant_urgent
);
    typedef struct packed {
        logic [N-1:0] gnt;
        logic         urg;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_PER-1:0] per_req_v, per_urg_v;
    logic [NUM_MEM-1:0] mem_req_v, mem_urg_v;
    logic [N-1:0]       req_vec, urg_vec;
    logic [N-1:0]       pick_urg, pick_norm;
    logic               any_urg, any_norm;

    dua_per_urg #(.NUM_PER(NUM_PER)) u_per (
        .per_req    (per_req),
        .per_tx     (per_tx),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .desc_pend  (desc_pend),
        .req_o      (per_req_v),
        .urg_o      (per_urg_v)
    );

    dua_mem_urg #(.NUM_MEM(NUM_MEM), .CNT_W(CNT_W)) u_mem (
        .mem_req      (mem_req),
        .mem_hs_en    (mem_hs_en),
        .mem_sw_urg   (mem_sw_urg),
        .mem_edge_cnt (mem_edge_cnt),
        .mem_urg_thr  (mem_urg_thr),
        .req_o        (mem_req_v),
        .urg_o        (mem_urg_v)
    );

    assign req_vec = {mem_req_v, per_req_v};
    assign urg_vec = {mem_urg_v, per_urg_v};

    dua_pick #(.N(N)) u_pick_urg (
        .req (urg_vec),
        .gnt (pick_urg),
        .any (any_urg)
    );

    dua_pick #(.N(N)) u_pick_norm (
        .req (req_vec),
        .gnt (pick_norm),
        .any (any_norm)
    );

    always_comb begin
        st_d = '0;
        if (bus_rdy) begin
            if (any_urg) begin
                st_d.gnt = pick_urg;
                st_d.urg = 1'b1;
            end else if (any_norm) begin
                st_d.gnt = pick_norm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign grant        = st_q.gnt;
    assign grant_urgent = st_q.urg;
endmodule

// File: rtl/dua_arb_checker.sv
module dua_arb_checker #(
    parameter int NUM_PER = 4,
    parameter int NUM_MEM = 2,
    parameter int CNT_W   = 8,
    localparam int N      = NUM_PER + NUM_MEM
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_rdy,
    input logic [N-1:0]             req_vec,
    input logic [N-1:0]             urg_vec,
    input logic [NUM_MEM-1:0]       mem_hs_en,
    input logic [NUM_MEM*CNT_W-1:0] mem_urg_thr,
    input logic [N-1:0]             grant,
    input logic                     grant_urgent
);
    p_grant_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_stall_no_grant_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rdy) |-> (grant == '0));

    p_urgent_first_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rdy && (|urg_vec)) |=> grant_urgent);

    p_flag_with_grant_r9: assert property (@(posedge clk) disable iff (rst)
        grant_urgent |-> (|grant));

    p_granted_was_asking_r7: assert property (@(posedge clk) disable iff (rst)
        (|grant) |-> (($past(req_vec) & grant) != '0));

    for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
        p_max_thr_never_r5: assert property (@(posedge clk) disable iff (rst)
            (mem_hs_en[g] && (&mem_urg_thr[g*CNT_W +: CNT_W])) |-> !urg_vec[NUM_PER+g]);
    end
endmodule

bind dma_urgent_arb dua_arb_checker #(
    .NUM_PER (NUM_PER),
    .NUM_MEM (NUM_MEM),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_rdy      (bus_rdy),
    .req_vec      (req_vec),
    .urg_vec      (urg_vec),
    .mem_hs_en    (mem_hs_en),
    .mem_urg_thr  (mem_urg_thr),
    .grant        (grant),
    .grant_urgent (grant_urgent)
);

// File: tb/dma_urgent_arb_test.sv
module dma_urgent_arb_test;
    localparam int P = 2;
    localparam int M = 1;
    localparam int W = 3;
    localparam int N = P + M;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_rdy = 1'b0;
    logic [P-1:0] per_req = '0, per_tx = '0, fifo_empty = '0, fifo_full = '0, desc_pend = '0;
    logic [M-1:0] mem_req = '0, mem_hs_en = '0, mem_sw_urg = '0;
    logic [M*W-1:0] mem_edge_cnt = '0, mem_urg_thr = '0;
    logic [N-1:0] grant;
    logic grant_urgent;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dma_urgent_arb #(.NUM_PER(P), .NUM_MEM(M), .CNT_W(W)) uut (
        .clk(clk), .rst(rst), .bus_rdy(bus_rdy),
        .per_req(per_req), .per_tx(per_tx), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .desc_pend(desc_pend),
        .mem_req(mem_req), .mem_hs_en(mem_hs_en), .mem_sw_urg(mem_sw_urg),
        .mem_edge_cnt(mem_edge_cnt), .mem_urg_thr(mem_urg_thr),
        .grant(grant), .grant_urgent(grant_urgent)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // expected outcome derived from the requirement text
    task automatic model(output logic [N-1:0] eg, output logic eu);
        logic [N-1:0] rq, ug;
        eg = '0;
        eu = 1'b0;
        for (int i = 0; i < P; i++) begin
            rq[i] = per_req[i] | desc_pend[i];
            ug[i] = per_req[i] & (per_tx[i] ? fifo_empty[i] : fifo_full[i]);
        end
        for (int j = 0; j < M; j++) begin
            int c, t;
            c = int'(mem_edge_cnt[j*W +: W]);
            t = int'(mem_urg_thr[j*W +: W]);
            rq[P+j] = mem_req[j];
            ug[P+j] = mem_req[j] & (mem_hs_en[j] ? (t != (1 << W) - 1 && c > t) : mem_sw_urg[j]);
        end
        if (bus_rdy) begin
            for (int i = N - 1; i >= 0; i--) if (ug[i]) begin eg = '0; eg[i] = 1'b1; end
            if (ug != '0) eu = 1'b1;
            else for (int i = N - 1; i >= 0; i--) if (rq[i]) begin eg = '0; eg[i] = 1'b1; end
        end
    endtask

    // drive at negedge, let one edge register it, sample at the next negedge
    task automatic step_and_check(input string gtag);
        logic [N-1:0] eg;
        logic eu;
        model(eg, eu);
        @(posedge clk);
        @(negedge clk);
        check(gtag, grant, eg);
        check("R9", {{(N-1){1'b0}}, grant_urgent}, {{(N-1){1'b0}}, eu});
        check("R10", {{(N-1){1'b0}}, ($countones(grant) > 1)}, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 grant", grant, '0);
        check("R1 flag", {{(N-1){1'b0}}, grant_urgent}, '0);
        rst = 1'b0;

        // sweep 1: every peripheral input pattern, memory channel varied
        for (int v = 0; v < 1024; v++) begin
            logic [9:0] b;
            b = v[9:0];
            per_req    = b[1:0];
            per_tx     = b[3:2];
            fifo_empty = b[5:4];
            fifo_full  = b[7:6];
            desc_pend  = b[9:8];
            mem_req    = M'(b[0] ^ b[5] ^ b[8]);
            mem_hs_en  = M'(b[3]);
            mem_sw_urg = M'(b[6] ^ b[9]);
            mem_edge_cnt = W'(v / 3);
            mem_urg_thr  = W'(v / 5);
            bus_rdy    = (v % 7) != 3;
            step_and_check(bus_rdy ? "R2,R3,R4,R7" : "R8");
        end

        // sweep 2: every memory channel field pattern against a
        // non-urgent peripheral request on channel 0
        for (int m = 0; m < 512; m++) begin
            logic [8:0] b;
            b = m[8:0];
            per_req    = 2'b01;
            per_tx     = 2'b01;
            fifo_empty = 2'b00;
            fifo_full  = 2'b00;
            desc_pend  = 2'b00;
            mem_req    = M'(b[0]);
            mem_hs_en  = M'(b[1]);
            mem_sw_urg = M'(b[2]);
            mem_edge_cnt = b[5:3];
            mem_urg_thr  = b[8:6];
            bus_rdy    = 1'b1;
            step_and_check(b[1] ? "R5,R3" : "R6,R3");
        end

        // descriptor-only request on a full receive FIFO stays non-urgent (R4)
        per_req = 2'b00; desc_pend = 2'b10; per_tx = 2'b00; fifo_full = 2'b10;
        mem_req = 1'b1; mem_hs_en = 1'b0; mem_sw_urg = 1'b0;
        step_and_check("R4,R7");

        // stalled slot after an urgent request (R8)
        per_req = 2'b10; per_tx = 2'b10; fifo_empty = 2'b10; bus_rdy = 1'b0;
        step_and_check("R8");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule